// File: doc/BRIEF.md
# Daisy-Chain Interrupt Request Handler

A reusable handler that sits between an interrupt-capable device and a CPU bus on which interrupts are acknowledged through a daisy-chained grant. The device raises a one-cycle request pulse. The handler latches that pulse and pulls the shared active-low interrupt line. It then waits for the grant to travel down the chain to it and, in the cycle after the grant is seen, places its stored 16-bit service routine vector on the data bus for the CPU to read. The device does not take part in the wait for its turn.

While it has nothing pending and nothing in service, the handler passes the upstream grant straight to its downstream neighbour. While a request is pending or being serviced, it holds the downstream grant inactive. Interrupts are gated by a dedicated enable bit and not by a reserved vector value, so vector 0x0000 is a real destination. A cancel input, or clearing the enable bit, withdraws a request that has not yet been granted. Once the acknowledge has started, withdrawal no longer has any effect.

The shared line and the data bus are modelled as drive enables. `irq_drive_o` high means the line is pulled low. `data_oe_o` high means the handler owns the bus.

Top module: `irq_chain_handler`

## Requirements
- R1: While reset is held, and directly after it, `irq_drive_o` and `data_oe_o` are 0, `data_o` is 0, and `grant_n_o` equals `grant_n_i`.
- R2: A request pulse is latched while `irq_en_i`=1 and `cancel_i`=0. From the next cycle on, `irq_drive_o`=1, and it stays 1 until the request is granted or withdrawn.
- R3: A pending request is granted when `grant_n_i`=0 is sampled with `cancel_i`=0 and `irq_en_i`=1. In the next cycle only, `data_oe_o`=1 and `data_o` carries the stored vector. At all other times `data_o` is 0.
- R4: `irq_drive_o` is released in the cycle after the acknowledge cycle, unless a new request is pending by then.
- R5: With nothing pending and nothing in service, `grant_n_o` follows `grant_n_i` combinationally, in the same cycle.
- R6: While a request is pending, in the acknowledge cycle and in the release cycle, `grant_n_o` is held at 1.
- R7: `cancel_i`=1 during a pending, ungranted request clears it. In the next cycle `irq_drive_o`=0, and a later grant produces no acknowledge and passes through.
- R8: `cancel_i` during the acknowledge cycle has no effect: the vector is still on the bus in that cycle.
- R9: A request pulse that arrives while `irq_en_i`=0 is ignored.
- R10: `irq_en_i`=0 during a pending, ungranted request clears it in the same way as `cancel_i`.
- R11: Vector 0x0000 is delivered as an ordinary vector, with `data_oe_o`=1.
- R12: Writing the vector (`vec_we_i`=1) takes effect from the next cycle. Toggling `irq_en_i` leaves the stored vector unchanged.
- R13: A second request that arrives while one is pending merges with it, so a single grant yields exactly one acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle interrupt request from the device |
| cancel_i | input | 1 | Withdraws a pending request that has not been granted |
| irq_en_i | input | 1 | Interrupt enable bit |
| vec_we_i | input | 1 | Write strobe for the service routine vector |
| vec_i | input | 16 | Service routine vector write data |
| grant_n_i | input | 1 | Upstream acknowledge grant, active low |
| grant_n_o | output | 1 | Downstream acknowledge grant, active low |
| irq_drive_o | output | 1 | Pull the shared active-low interrupt line |
| data_o | output | 16 | Vector driven toward the data bus |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
The downstream grant is combinational and is due in the same cycle as the upstream grant. The interrupt line follows a request one cycle after the pulse. The vector appears one cycle after the grant is sampled, and the line is released one cycle after that. The bench drives inputs at the falling edge and compares every output against a behavioural model 1 ns later, before the next rising edge. This way each same-cycle result is seen in the cycle it is due, and each registered result is seen in the cycle after its cause. Directed sequences cover cancel and disable in each phase, vector zero, merged requests and grant pass-through, and a long random phase covers the remaining interleavings.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  typedef enum logic [1:0] {
    SVC_IDLE = 2'd0,
    SVC_ACK  = 2'd1,
    SVC_REL  = 2'd2
  } svc_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic cancel_i,
  input  logic irq_en_i,
  input  logic grant_n_i,
  input  logic svc_idle_i,
  output logic pend_o,
  output logic take_o
);
  logic pend_q;
  logic withdraw;
  logic set;

  assign withdraw = cancel_i | ~irq_en_i;
  assign set      = req_i & ~withdraw;
  // grant is honoured only when no earlier acknowledge is still in flight
  assign take_o   = pend_q & ~grant_n_i & svc_idle_i & ~withdraw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= set | (pend_q & ~take_o & ~withdraw);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_svc_seq.sv
module irq_svc_seq
  import irq_chain_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic idle_o,
  output logic ack_o
);
  svc_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SVC_IDLE: if (take_i) state_d = SVC_ACK;
      SVC_ACK:  state_d = SVC_REL;
      SVC_REL:  state_d = SVC_IDLE;
      default:  state_d = SVC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SVC_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o = (state_q == SVC_IDLE);
  assign ack_o  = (state_q == SVC_ACK);
endmodule

// File: rtl/irq_grant_steer.sv
module irq_grant_steer (
  input  logic pend_i,
  input  logic svc_idle_i,
  input  logic ack_i,
  input  logic grant_n_i,
  output logic grant_n_o,
  output logic irq_drive_o
);
  logic busy;

  assign busy        = pend_i | ~svc_idle_i;
  assign grant_n_o   = busy ? 1'b1 : grant_n_i;
  assign irq_drive_o = pend_i | ack_i;
endmodule

// File: rtl/irq_vec_store.sv
module irq_vec_store #(
  parameter int VEC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vec_we_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             ack_i,
  output logic [VEC_W-1:0] data_o,
  output logic             data_oe_o
);
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       vec_q <= '0;
    else if (vec_we_i) vec_q <= vec_i;
  end

  assign data_oe_o = ack_i;
  assign data_o    = ack_i ? vec_q : '0;
endmodule

// File: rtl/irq_chain_handler.sv
module irq_chain_handler #(
  parameter int VEC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             cancel_i,
  input  logic             irq_en_i,
  input  logic             vec_we_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             grant_n_i,
  output logic             grant_n_o,
  output logic             irq_drive_o,
  output logic [VEC_W-1:0] data_o,
  output logic             data_oe_o
);
  logic pend, take, svc_idle, ack;

  irq_req_latch i_latch (
    .clk_i, .rst_ni, .req_i, .cancel_i, .irq_en_i, .grant_n_i,
    .svc_idle_i(svc_idle), .pend_o(pend), .take_o(take)
  );

  irq_svc_seq i_seq (
    .clk_i, .rst_ni, .take_i(take), .idle_o(svc_idle), .ack_o(ack)
  );

  irq_grant_steer i_steer (
    .pend_i(pend), .svc_idle_i(svc_idle), .ack_i(ack), .grant_n_i,
    .grant_n_o, .irq_drive_o
  );

  irq_vec_store #(.VEC_W(VEC_W)) i_vec (
    .clk_i, .rst_ni, .vec_we_i, .vec_i, .ack_i(ack), .data_o, .data_oe_o
  );
endmodule

// File: rtl/irq_chain_checker.sv
module irq_chain_checker #(
  parameter int VEC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cancel_i,
  input logic             irq_en_i,
  input logic             grant_n_i,
  input logic             grant_n_o,
  input logic             irq_drive_o,
  input logic [VEC_W-1:0] data_o,
  input logic             data_oe_o
);
  assert_ack_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |=> !data_oe_o);
  assert_bus_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);
  assert_hold_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_drive_o |-> grant_n_o);
  assert_no_phantom_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_n_o |-> !grant_n_i);
  assert_ack_with_line_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> irq_drive_o);
  assert_cancel_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_drive_o && !data_oe_o && cancel_i) |=> !irq_drive_o);
  assert_disabled_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_drive_o && !irq_en_i) |=> !irq_drive_o);
endmodule

bind irq_chain_handler irq_chain_checker #(.VEC_W(VEC_W)) i_checker (
  .clk_i, .rst_ni, .cancel_i, .irq_en_i, .grant_n_i, .grant_n_o,
  .irq_drive_o, .data_o, .data_oe_o
);

// File: tb/test_irq_chain_handler.sv
`timescale 1ns/1ps
module test_irq_chain_handler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, cancel = 1'b0, en = 1'b0, vec_we = 1'b0;
  logic [15:0] vec = '0;
  logic        gnt_n = 1'b1;
  logic        gnt_n_o, drive, oe;
  logic [15:0] data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_chain_handler i_irq_chain_handler (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cancel_i(cancel),
    .irq_en_i(en), .vec_we_i(vec_we), .vec_i(vec), .grant_n_i(gnt_n),
    .grant_n_o(gnt_n_o), .irq_drive_o(drive), .data_o(data), .data_oe_o(oe)
  );

  // behavioural reference
  bit     m_pend;
  int     m_phase;     // 0 idle, 1 acknowledge, 2 release
  int     m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= 0; m_phase <= 0; m_vec <= 0;
    end else begin
      bit wd, tk;
      wd = cancel || !en;
      tk = m_pend && !gnt_n && (m_phase == 0) && !wd;
      m_pend  <= (req && !wd) || (m_pend && !tk && !wd);
      m_phase <= (m_phase == 1) ? 2 : (m_phase == 2) ? 0 : (tk ? 1 : 0);
      if (vec_we) m_vec <= int'(vec);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk("R2 irq_drive", int'(drive), int'(m_pend || m_phase == 1));
    chk("R3 data_oe", int'(oe), int'(m_phase == 1));
    chk("R3 data", int'(data), (m_phase == 1) ? m_vec : 0);
    chk("R6 grant_n_o", int'(gnt_n_o), (m_pend || m_phase != 0) ? 1 : int'(gnt_n));
  endtask

  // drive one cycle at the falling edge, compare 1 ns later
  task automatic cyc(bit r, bit c, bit e, bit g_n);
    @(negedge clk);
    req = r; cancel = c; en = e; gnt_n = g_n; vec_we = 0;
    #1;
    cmp_model();
  endtask

  task automatic wr_vec(logic [15:0] v);
    @(negedge clk);
    req = 0; cancel = 0; gnt_n = 1; vec_we = 1; vec = v;
    #1;
    cmp_model();
  endtask

  initial begin
    // R1: reset state
    en = 1; gnt_n = 0;
    #7;
    chk("R1 drive in reset", int'(drive), 0);
    chk("R1 oe in reset", int'(oe), 0);
    chk("R1 data in reset", int'(data), 0);
    chk("R1 grant pass in reset", int'(gnt_n_o), 0);
    @(negedge clk); rst_n = 1; gnt_n = 1;
    #1;
    chk("R1 grant pass after reset", int'(gnt_n_o), 1);

    // R2 R3 R4 R6 basic acknowledge
    wr_vec(16'h1234);
    cyc(1, 0, 1, 1);
    chk("R2 not yet", int'(drive), 0);
    cyc(0, 0, 1, 1);
    chk("R2 line pulled", int'(drive), 1);
    cyc(0, 0, 1, 1);
    chk("R2 line held", int'(drive), 1);
    cyc(0, 0, 1, 0);
    chk("R6 grant held", int'(gnt_n_o), 1);
    cyc(0, 0, 1, 1);
    chk("R3 oe", int'(oe), 1);
    chk("R3 vector", int'(data), 16'h1234);
    cyc(0, 0, 1, 0);
    chk("R4 released", int'(drive), 0);
    chk("R6 grant held in release", int'(gnt_n_o), 1);
    chk("R3 single ack", int'(oe), 0);

    // R5 pass-through
    cyc(0, 0, 1, 0);
    chk("R5 pass low", int'(gnt_n_o), 0);
    cyc(0, 0, 1, 1);
    chk("R5 pass high", int'(gnt_n_o), 1);

    // R7 cancel while waiting
    cyc(1, 0, 1, 1);
    cyc(0, 1, 1, 1);
    chk("R7 still pending", int'(drive), 1);
    cyc(0, 0, 1, 0);
    chk("R7 cleared", int'(drive), 0);
    chk("R7 grant passes", int'(gnt_n_o), 0);
    cyc(0, 0, 1, 1);
    chk("R7 no ack", int'(oe), 0);

    // R8 cancel during acknowledge
    cyc(1, 0, 1, 1);
    cyc(0, 0, 1, 0);
    cyc(0, 1, 1, 1);
    chk("R8 ack survives cancel", int'(oe), 1);
    chk("R8 vector", int'(data), 16'h1234);
    cyc(0, 0, 1, 1);

    // R9 request while disabled
    cyc(1, 0, 0, 1);
    cyc(0, 0, 1, 1);
    chk("R9 ignored", int'(drive), 0);
    cyc(0, 0, 1, 0);
    chk("R9 grant passes", int'(gnt_n_o), 0);

    // R10 disable while waiting
    cyc(1, 0, 1, 1);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 1, 0);
    chk("R10 cleared", int'(drive), 0);
    cyc(0, 0, 1, 1);
    chk("R10 no ack", int'(oe), 0);

    // R11 vector zero
    wr_vec(16'h0000);
    cyc(1, 0, 1, 1);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 1);
    chk("R11 oe for zero", int'(oe), 1);
    chk("R11 zero vector", int'(data), 0);
    cyc(0, 0, 1, 1);

    // R12 vector kept across enable toggle
    wr_vec(16'hBEEF);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    cyc(1, 0, 1, 1);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 1);
    chk("R12 vector kept", int'(data), 16'hBEEF);
    cyc(0, 0, 1, 1);

    // R13 merged requests
    cyc(1, 0, 1, 1);
    cyc(1, 0, 1, 1);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 1);
    chk("R13 one ack", int'(oe), 1);
    cyc(0, 0, 1, 1);
    chk("R13 no second ack", int'(oe), 0);
    chk("R13 line free", int'(drive), 0);
    cyc(0, 0, 1, 1);
    chk("R13 still free", int'(drive), 0);

    // random interleavings against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      req    = ($urandom_range(0, 5) == 0);
      cancel = ($urandom_range(0, 9) == 0);
      en     = ($urandom_range(0, 11) != 0);
      gnt_n  = ($urandom_range(0, 3) != 0);
      vec_we = ($urandom_range(0, 15) == 0);
      vec    = 16'($urandom);
      #1;
      cmp_model();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule